// File: doc/BRIEF.md
# Gold Code Chip Generator

This block produces a 31-chip Gold spreading code for a direct-sequence spread-spectrum modem. It holds two five-stage maximal-length shift registers that advance together on every chip enable. Each register yields one m-sequence bit, and the Gold chip is the exclusive-OR of the two bits. A transmitter XORs each information bit with the Gold chip stream. Each information bit then covers exactly one full code period.

The first register's five stages are also decoded for the all-ones state. That state occurs once in every 31 chips, so the decode gives a data-bit strobe that marks the start of each code period. No separate bit-rate divider is needed.

A receiver searching for code phase can use two slip inputs. Retard skips one chip. Advance takes two steps in one chip. Both move the code by one chip relative to the incoming signal without reseeding. The seeds are sampled only while synchronous reset is high. The generator runs on its chip-enable and has no back-pressure: a consumer that cannot take a chip holds `chip_en` low, and the code then freezes in place.

Top module: `gold_chip_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, each register loads its seed. Seed bit 0 is stage 1 and seed bit 4 is stage 5. Straight after reset, `m_a` and `m_b` show bit 4 of the respective effective seeds.
- R2: A seed of all zeros is replaced by all ones, so after such a reset `m_a`, `m_b` and `bit_strobe` all read 1.
- R3: On a normal step every stage k+1 takes the old stage k. Stage 1 of register A takes stage 3 XOR stage 5 (polynomial 1 + x^2 + x^5). The output sequence then obeys a(n+5) = a(n+2) XOR a(n), and `m_a` is stage 5.
- R4: Register B uses polynomial 1 + x^2 + x^3 + x^4 + x^5, so b(n+5) = b(n) XOR b(n+2) XOR b(n+3) XOR b(n+4), and `m_b` is its stage 5.
- R5: Both m-sequences repeat every 31 steps for every nonzero seed, with exactly 16 ones per period.
- R6: `gold_chip` equals `m_a` XOR `m_b` at all times.
- R7: `bit_strobe` is 1 exactly when all five stages of register A are 1. It therefore asserts once in every 31 consecutive steps and never on two consecutive steps.
- R8: With `chip_en` low, both registers hold, and the slip inputs are ignored.
- R9: With `chip_en` high, `slip_ret` high and `slip_adv` low, both registers hold for that cycle (code retarded by one chip).
- R10: With `chip_en` high, `slip_adv` high and `slip_ret` low, both registers take two steps in that cycle (code advanced by one chip).
- R11: With `chip_en` high and both slip inputs high, the requests cancel and both registers take one normal step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous reset; loads the seeds |
| chip_en | input | 1 | Advance the code by one step this cycle |
| slip_adv | input | 1 | Take an extra step on this enabled cycle |
| slip_ret | input | 1 | Skip the step on this enabled cycle |
| seed_a | input | 5 | Reset seed for register A (bit 0 = stage 1) |
| seed_b | input | 5 | Reset seed for register B (bit 0 = stage 1) |
| m_a | output | 1 | Stage 5 of register A |
| m_b | output | 1 | Stage 5 of register B |
| gold_chip | output | 1 | Gold code chip, `m_a` XOR `m_b` |
| bit_strobe | output | 1 | High while register A is in its all-ones state |

## Verification
The bench builds the block with its default five stages and the two default polynomials. That gives a state space small enough to sweep every nonzero seed of register A, each paired with a varying seed of B. For each seed the bench checks a full period chip by chip against a recurrence computed in the bench, and counts the ones and strobes over that period. The same small configuration keeps each slip and hold case within a few dozen cycles. The bench can therefore follow the expected code index exactly through retard, advance, cancelled and disabled slips.

// File: rtl/gold_pkg.sv
package gold_pkg;

  // Default register length and feedback polynomials.
  // Bit k of a polynomial is the coefficient of x^k; x^STAGES is implied.
  localparam int unsigned    GOLD_STAGES = 5;
  localparam logic [4:0]     GOLD_POLY_A = 5'b00101;  // 1 + x^2 + x^5
  localparam logic [4:0]     GOLD_POLY_B = 5'b11101;  // 1 + x^2 + x^3 + x^4 + x^5

  // Number of register steps to take in one clock cycle.
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_e;

endpackage

// File: rtl/gold_slip_ctl.sv
module gold_slip_ctl
  import gold_pkg::*;
(
  input  logic  chip_en,
  input  logic  slip_adv,
  input  logic  slip_ret,
  output step_e step
);

  // Retard drops the step, advance doubles it, both together cancel.
  always_comb begin
    if (!chip_en) begin
      step = STEP_NONE;
    end else if (slip_adv == slip_ret) begin
      step = STEP_ONE;
    end else if (slip_ret) begin
      step = STEP_NONE;
    end else begin
      step = STEP_TWO;
    end
  end

endmodule

// File: rtl/gold_lfsr.sv
module gold_lfsr
  import gold_pkg::*;
#(
  parameter int unsigned        STAGES = 5,
  parameter logic [STAGES-1:0]  POLY   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] seed,
  input  step_e             step,
  output logic [STAGES-1:0] state
);

  // state[0] is stage 1 (newest bit), state[STAGES-1] is the output stage.
  // Coefficient k of the polynomial selects the bit emitted k steps later,
  // which sits in stage STAGES-k.
  function automatic logic [STAGES-1:0] mask_of(input logic [STAGES-1:0] p);
    logic [STAGES-1:0] m;
    for (int k = 0; k < int'(STAGES); k++) begin
      m[STAGES-1-k] = p[k];
    end
    return m;
  endfunction

  localparam logic [STAGES-1:0] TAPS = mask_of(POLY);

  function automatic logic [STAGES-1:0] advance(input logic [STAGES-1:0] s);
    return {s[STAGES-2:0], ^(s & TAPS)};
  endfunction

  logic [STAGES-1:0] seed_fixed;
  logic [STAGES-1:0] one_step;
  logic [STAGES-1:0] two_step;

  // The all-zero state never leaves itself; substitute all ones.
  assign seed_fixed = (seed == '0) ? '1 : seed;
  assign one_step   = advance(state);
  assign two_step   = advance(one_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= seed_fixed;
    end else begin
      unique case (step)
        STEP_ONE: state <= one_step;
        STEP_TWO: state <= two_step;
        default:  state <= state;
      endcase
    end
  end

endmodule

// File: rtl/gold_frame_dec.sv
module gold_frame_dec #(
  parameter int unsigned STAGES = 5
) (
  input  logic [STAGES-1:0] state,
  output logic              frame
);

  // The all-ones state appears once per maximal-length period.
  assign frame = &state;

endmodule

// File: rtl/gold_chip_gen.sv
module gold_chip_gen
  import gold_pkg::*;
#(
  parameter int unsigned        STAGES = GOLD_STAGES,
  parameter logic [STAGES-1:0]  POLY_A = GOLD_POLY_A,
  parameter logic [STAGES-1:0]  POLY_B = GOLD_POLY_B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              slip_adv,
  input  logic              slip_ret,
  input  logic [STAGES-1:0] seed_a,
  input  logic [STAGES-1:0] seed_b,
  output logic              m_a,
  output logic              m_b,
  output logic              gold_chip,
  output logic              bit_strobe
);

  localparam int unsigned OUT_STAGE = STAGES - 1;

  step_e             step;
  logic [STAGES-1:0] st_a;
  logic [STAGES-1:0] st_b;

  gold_slip_ctl u_slip (
    .chip_en  (chip_en),
    .slip_adv (slip_adv),
    .slip_ret (slip_ret),
    .step     (step)
  );

  gold_lfsr #(.STAGES(STAGES), .POLY(POLY_A)) u_reg_a (
    .clk   (clk),
    .rst   (rst),
    .seed  (seed_a),
    .step  (step),
    .state (st_a)
  );

  gold_lfsr #(.STAGES(STAGES), .POLY(POLY_B)) u_reg_b (
    .clk   (clk),
    .rst   (rst),
    .seed  (seed_b),
    .step  (step),
    .state (st_b)
  );

  gold_frame_dec #(.STAGES(STAGES)) u_frame (
    .state (st_a),
    .frame (bit_strobe)
  );

  assign m_a       = st_a[OUT_STAGE];
  assign m_b       = st_b[OUT_STAGE];
  assign gold_chip = m_a ^ m_b;

endmodule

// File: rtl/gold_chip_gen_chk.sv
module gold_chip_gen_chk #(
  parameter int unsigned STAGES = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en,
  input logic              slip_adv,
  input logic              slip_ret,
  input logic [STAGES-1:0] st_a,
  input logic [STAGES-1:0] st_b,
  input logic              bit_strobe
);

  // R2: neither register ever reaches the locked all-zero state
  a_r2_no_lockup: assert property (@(posedge clk) disable iff (rst)
    (st_a != '0) && (st_b != '0));

  // R3: a plain step shifts every stage up by one
  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    (chip_en && !slip_adv && !slip_ret) |=>
      (st_a[STAGES-1:1] == $past(st_a[STAGES-2:0])) &&
      (st_b[STAGES-1:1] == $past(st_b[STAGES-2:0])));

  // R7: the period strobe never lasts into the following step
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && chip_en && !slip_ret) |=> !bit_strobe);

  // R8: disabled cycles leave both registers unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> $stable(st_a) && $stable(st_b));

  // R9: a retard request freezes the code for one cycle
  a_r9_retard: assert property (@(posedge clk) disable iff (rst)
    (chip_en && slip_ret && !slip_adv) |=> $stable(st_a) && $stable(st_b));

  // R10: an advance request shifts every stage up by two
  a_r10_advance: assert property (@(posedge clk) disable iff (rst)
    (chip_en && slip_adv && !slip_ret) |=>
      (st_a[STAGES-1:2] == $past(st_a[STAGES-3:0])) &&
      (st_b[STAGES-1:2] == $past(st_b[STAGES-3:0])));

endmodule

bind gold_chip_gen gold_chip_gen_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_en    (chip_en),
  .slip_adv   (slip_adv),
  .slip_ret   (slip_ret),
  .st_a       (st_a),
  .st_b       (st_b),
  .bit_strobe (bit_strobe)
);

// File: tb/tb_gold_chip_gen.sv
module tb_gold_chip_gen;

  localparam logic [4:0] PA = 5'b00101;  // 1 + x^2 + x^5
  localparam logic [4:0] PB = 5'b11101;  // 1 + x^2 + x^3 + x^4 + x^5

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_en = 1'b0;
  logic       slip_adv = 1'b0;
  logic       slip_ret = 1'b0;
  logic [4:0] seed_a = '0;
  logic [4:0] seed_b = '0;
  logic       m_a, m_b, gold_chip, bit_strobe;

  int         n_chk = 0;
  int         n_fail = 0;
  int         idx = 0;
  logic [4:0] eff_a = '1;
  logic [4:0] eff_b = '1;
  bit         done = 1'b0;

  gold_chip_gen dut (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .slip_adv   (slip_adv),
    .slip_ret   (slip_ret),
    .seed_a     (seed_a),
    .seed_b     (seed_b),
    .m_a        (m_a),
    .m_b        (m_b),
    .gold_chip  (gold_chip),
    .bit_strobe (bit_strobe)
  );

  always #2 clk = ~clk;

  // Sequence bit n from the recurrence; seed bit 4 is emitted first.
  function automatic logic seq_bit(input logic [4:0] seed, input logic [4:0] poly,
                                   input int n);
    logic [399:0] a;
    logic         fb;
    a = '0;
    for (int i = 0; i < 5; i++) a[i] = seed[4-i];
    for (int i = 5; i <= n; i++) begin
      fb = 1'b0;
      for (int k = 0; k < 5; k++) if (poly[k]) fb = fb ^ a[i-5+k];
      a[i] = fb;
    end
    return a[n];
  endfunction

  function automatic logic exp_strobe(input logic [4:0] seed, input int n);
    logic r;
    r = 1'b1;
    for (int j = 0; j < 5; j++) r = r & seq_bit(seed, PA, n + j);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    logic ea, eb, es;
    ea = seq_bit(eff_a, PA, idx);
    eb = seq_bit(eff_b, PB, idx);
    es = exp_strobe(eff_a, idx);
    check(m_a === ea, {req, " (R3) m_a"}, int'(m_a), int'(ea));
    check(m_b === eb, {req, " (R4) m_b"}, int'(m_b), int'(eb));
    check(gold_chip === (ea ^ eb), {req, " (R6) gold_chip"}, int'(gold_chip), int'(ea ^ eb));
    check(bit_strobe === es, {req, " (R7) bit_strobe"}, int'(bit_strobe), int'(es));
  endtask

  // Drive at a falling edge, return at the next falling edge.
  task automatic cyc(input logic en, input logic adv, input logic ret);
    chip_en  = en;
    slip_adv = adv;
    slip_ret = ret;
    @(negedge clk);
    chip_en  = 1'b0;
    slip_adv = 1'b0;
    slip_ret = 1'b0;
  endtask

  task automatic do_reset(input logic [4:0] sa, input logic [4:0] sb);
    seed_a = sa;
    seed_b = sb;
    rst    = 1'b1;
    @(negedge clk);
    rst    = 1'b0;
    eff_a  = (sa == 5'd0) ? 5'h1f : sa;
    eff_b  = (sb == 5'd0) ? 5'h1f : sb;
    idx    = 0;
  endtask

  initial begin
    int ones_a, ones_b, strobes;
    logic first_a, first_b;

    // R1: seed load and first outputs
    do_reset(5'b10011, 5'b01101);
    check(m_a === 1'b1, "R1 m_a after reset", int'(m_a), 1);
    check(m_b === 1'b0, "R1 m_b after reset", int'(m_b), 0);
    check_outputs("R1 reset state");

    // R3 R4 R5 R6 R7: two full periods chip by chip
    ones_a = 0; ones_b = 0; strobes = 0;
    for (int i = 0; i < 62; i++) begin
      if (i < 31) begin
        ones_a += int'(m_a);
        ones_b += int'(m_b);
        strobes += int'(bit_strobe);
      end
      cyc(1'b1, 1'b0, 1'b0);
      idx++;
      check_outputs("R3 free run");
    end
    check(ones_a == 16, "R5 ones in A period", ones_a, 16);
    check(ones_b == 16, "R5 ones in B period", ones_b, 16);
    check(strobes == 1, "R7 strobes per period", strobes, 1);

    // R8: disabled cycles hold, slips ignored while disabled
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, i[0], i[1]);
      check_outputs("R8 hold with chip_en low");
    end

    // R9: retard
    cyc(1'b1, 1'b0, 1'b1);
    check_outputs("R9 retard holds");
    cyc(1'b1, 1'b0, 1'b0);
    idx++;
    check_outputs("R9 step after retard");

    // R10: advance
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b1, 1'b0);
      idx += 2;
      check_outputs("R10 advance double step");
    end

    // R11: both slips cancel
    cyc(1'b1, 1'b1, 1'b1);
    idx++;
    check_outputs("R11 both slips single step");

    // R2: zero seeds
    do_reset(5'd0, 5'd0);
    check(m_a === 1'b1, "R2 m_a zero seed", int'(m_a), 1);
    check(m_b === 1'b1, "R2 m_b zero seed", int'(m_b), 1);
    check(bit_strobe === 1'b1, "R2 strobe zero seed", int'(bit_strobe), 1);
    cyc(1'b1, 1'b0, 1'b0);
    idx++;
    check_outputs("R2 step after zero seed");

    // R5 R7: sweep every nonzero seed of A with varying B seeds
    for (int s = 1; s < 32; s++) begin
      do_reset(s[4:0], s[4:0] ^ 5'b01010);
      first_a = m_a;
      first_b = m_b;
      ones_a = 0; ones_b = 0; strobes = 0;
      for (int i = 0; i < 31; i++) begin
        check_outputs("R5 seed sweep");
        ones_a += int'(m_a);
        ones_b += int'(m_b);
        strobes += int'(bit_strobe);
        cyc(1'b1, 1'b0, 1'b0);
        idx++;
      end
      check(ones_a == 16, "R5 sweep ones A", ones_a, 16);
      check(ones_b == 16, "R5 sweep ones B", ones_b, 16);
      check(strobes == 1, "R7 sweep strobes", strobes, 1);
      check(m_a === first_a, "R5 A period 31", int'(m_a), int'(first_a));
      check(m_b === first_b, "R5 B period 31", int'(m_b), int'(first_b));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule